// File: doc/BRIEF.md
# ADC Conversion Sequencer Controller

This block is the digital half of a successive-approximation converter. Software programs a small register bank over a simple word-addressed bus. The bank holds a clock prescaler, a resolution code, a per-channel sampling time and a list of up to sixteen channel slots with a length field and a scan switch. A write to the start bit begins a sequence. For each slot in turn, the controller drives the slot's channel number on a select output. It then holds a sample-enable window open for the programmed number of converter-clock cycles and waits the conversion time implied by the resolution. At the end it captures the result word presented by the analog side and raises an end-of-conversion flag.

The converter clock is never a real clock. It exists as a single-cycle enable that the bus-clock prescaler produces, and the divider is re-phased on every accepted start. Because of this, every window and every conversion lasts an exact multiple of the division ratio, counted in bus cycles. Reading the data register returns the right-aligned result and clears the flag.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The prescaler code in bits 17:16 of the common register (address 9) sets the bus clocks per converter cycle: 00 gives 2, 01 gives 4, 10 gives 6 and 11 gives 8.
- R2: Each channel has a 3-bit sample code. Channels 0 to 9 use bits 3c+2:3c of address 4, and channels 10 to 18 use bits 3(c-10)+2:3(c-10) of address 3. Codes 000 to 111 give 3, 15, 28, 56, 84, 112, 144 and 480 converter cycles. `sample_en` stays high for exactly that count times the ratio from R1.
- R3: The resolution code in bits 25:24 of address 1 (reset 00) sets the conversion time that follows the sample window. Code 00 gives 15 converter cycles, 01 gives 13, 10 gives 11 and 11 gives 9.
- R4: The data register (address 8) holds the low 12, 10, 8 or 6 bits of `conv_result`, for resolution codes 00, 01, 10 and 11. The value is sampled in the cycle the conversion ends, and all upper bits read as zero.
- R5: Slot k holds a 5-bit channel. Slots 0 to 5 sit in bits 5k+4:5k of address 7, slots 6 to 11 in address 6 and slots 12 to 15 in address 5, with slot 0 in bits 4:0 of address 7. `ch_sel` shows the channel of the active slot throughout that slot's window and conversion.
- R6: The length field is bits 23:20 of address 5 and the scan bit is bit 8 of address 1. With scan at 0 only slot 0 is converted, whatever the length. With scan at 1, slots 0 up to the length value are converted in order, so a length of 0 gives one conversion.
- R7: A write to address 2 with bit 30 set, made while idle, starts a sequence in the next cycle. A write with bit 30 clear, or any start request while a sequence runs, has no effect.
- R8: At the end of every conversion, the end-of-conversion flag is set. It is visible on `eoc` and as bit 1 of the status register (address 0).
- R9: A read of address 8 clears the flag. When a read and a conversion end fall in the same cycle, the flag stays set. Writes to address 8 leave the data unchanged.
- R10: After reset, `sample_en`, `eoc` and `ch_sel` are zero and the data and status registers read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 4 | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, combinational, zero when not reading |
| conv_result | input | 12 | Result word from the analog side |
| ch_sel | output | 5 | Channel select for the input multiplexer |
| sample_en | output | 1 | Sample-and-hold window |
| eoc | output | 1 | End-of-conversion flag |

## Verification
The hazardous coincidence is a software read of the data register in the same bus cycle that a conversion ends. In that cycle one function clears the flag and the other sets it and overwrites the data. The bench uses its reference model to locate the last cycle of a conversion and places the read strobe in exactly that cycle. It then judges two things: the read must return the previous result, and in the following cycle `eoc` must remain high with the new result in place.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

   typedef enum logic [1:0] {
      SEQ_IDLE    = 2'd0,
      SEQ_SAMPLE  = 2'd1,
      SEQ_CONVERT = 2'd2
   } seq_state_e;

   localparam int unsigned BUS_W = 32;
   localparam int unsigned ADDR_W = 4;

   localparam logic [ADDR_W-1:0] A_STATUS = 4'd0;
   localparam logic [ADDR_W-1:0] A_CTRL1  = 4'd1;
   localparam logic [ADDR_W-1:0] A_CTRL2  = 4'd2;
   localparam logic [ADDR_W-1:0] A_SMP_HI = 4'd3;
   localparam logic [ADDR_W-1:0] A_SMP_LO = 4'd4;
   localparam logic [ADDR_W-1:0] A_SEQ1   = 4'd5;
   localparam logic [ADDR_W-1:0] A_SEQ2   = 4'd6;
   localparam logic [ADDR_W-1:0] A_SEQ3   = 4'd7;
   localparam logic [ADDR_W-1:0] A_DATA   = 4'd8;
   localparam logic [ADDR_W-1:0] A_COMMON = 4'd9;

   localparam int unsigned SCAN_BIT  = 8;
   localparam int unsigned RES_LSB   = 24;
   localparam int unsigned START_BIT = 30;
   localparam int unsigned EOC_BIT   = 1;
   localparam int unsigned LEN_LSB   = 20;
   localparam int unsigned PRE_LSB   = 16;

   localparam int unsigned SMP_CODE_W = 3;
   localparam int unsigned MAX_SMP    = 480;
   localparam int unsigned PH_W       = $clog2(MAX_SMP + 1);

   function automatic int unsigned smp_cycles(input logic [SMP_CODE_W-1:0] code);
      case (code)
         3'd0:    return 3;
         3'd1:    return 15;
         3'd2:    return 28;
         3'd3:    return 56;
         3'd4:    return 84;
         3'd5:    return 112;
         3'd6:    return 144;
         default: return MAX_SMP;
      endcase
   endfunction

   function automatic int unsigned conv_cycles(input logic [1:0] res, input int unsigned full_w);
      return full_w + 3 - 2 * int'(res);
   endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div #(
   parameter int unsigned PRE_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [PRE_W-1:0] presc,
   output logic             tick
);
   localparam int unsigned CNT_W = PRE_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] limit;

   // ratio is 2*(code+1), so the terminal count is 2*code+1
   assign limit = {presc, 1'b1};
   assign tick  = (cnt_q >= limit);

   always_ff @(posedge clk) begin
      if (!rst_n)              cnt_q <= '0;
      else if (restart || tick) cnt_q <= '0;
      else                     cnt_q <= cnt_q + 1'b1;
   end

   // R1
   tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick);

endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
   import adc_seq_pkg::*;
#(
   parameter int unsigned NUM_CH = 19,
   parameter int unsigned CH_W   = 5,
   parameter int unsigned LEN_W  = 4,
   parameter int unsigned RES_W  = 12
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               start,
   input  logic                               tick,
   input  logic                               scan,
   input  logic [LEN_W-1:0]                   seq_len,
   input  logic [1:0]                         res_code,
   input  logic [(2**LEN_W)*CH_W-1:0]         slots_flat,
   input  logic [NUM_CH*SMP_CODE_W-1:0]       smp_flat,
   output logic [CH_W-1:0]                    ch_sel,
   output logic                               sample_en,
   output logic                               busy,
   output logic                               conv_done,
   output logic                               div_restart
);
   localparam int unsigned SLOTS = 2 ** LEN_W;

   seq_state_e            state_q;
   logic [LEN_W-1:0]      idx_q;
   logic [LEN_W-1:0]      last_q;
   logic [PH_W-1:0]       ph_q;
   logic [CH_W-1:0]       ch_q;
   logic [CH_W-1:0]       slot_a [SLOTS];
   logic [SMP_CODE_W-1:0] smp_a  [NUM_CH];
   logic [SMP_CODE_W-1:0] cur_code;
   logic [PH_W-1:0]       samp_last;
   logic [PH_W-1:0]       conv_last;
   logic [LEN_W-1:0]      next_idx;
   logic                  samp_end;
   logic                  go;

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot
      assign slot_a[g] = slots_flat[g*CH_W +: CH_W];
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_smp
      assign smp_a[g] = smp_flat[g*SMP_CODE_W +: SMP_CODE_W];
   end

   always_comb begin
      cur_code = '0;
      for (int i = 0; i < NUM_CH; i++) begin
         if (ch_q == CH_W'(i)) cur_code = smp_a[i];
      end
   end

   assign samp_last   = PH_W'(smp_cycles(cur_code) - 1);
   assign conv_last   = PH_W'(conv_cycles(res_code, RES_W) - 1);
   assign next_idx    = idx_q + 1'b1;
   assign go          = start && (state_q == SEQ_IDLE);
   assign samp_end    = (state_q == SEQ_SAMPLE) && tick && (ph_q == samp_last);
   assign conv_done   = (state_q == SEQ_CONVERT) && tick && (ph_q == conv_last);
   assign div_restart = go;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= SEQ_IDLE;
         idx_q   <= '0;
         last_q  <= '0;
         ph_q    <= '0;
         ch_q    <= '0;
      end else begin
         case (state_q)
            SEQ_IDLE: begin
               if (go) begin
                  state_q <= SEQ_SAMPLE;
                  idx_q   <= '0;
                  ph_q    <= '0;
                  ch_q    <= slot_a[0];
                  last_q  <= scan ? seq_len : '0;
               end
            end
            SEQ_SAMPLE: begin
               if (samp_end) begin
                  ph_q    <= '0;
                  state_q <= SEQ_CONVERT;
               end else if (tick) begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            SEQ_CONVERT: begin
               if (conv_done) begin
                  ph_q <= '0;
                  if (idx_q == last_q) begin
                     state_q <= SEQ_IDLE;
                  end else begin
                     idx_q   <= next_idx;
                     ch_q    <= slot_a[next_idx];
                     state_q <= SEQ_SAMPLE;
                  end
               end else if (tick) begin
                  ph_q <= ph_q + 1'b1;
               end
            end
            default: state_q <= SEQ_IDLE;
         endcase
      end
   end

   assign ch_sel    = ch_q;
   assign sample_en = (state_q == SEQ_SAMPLE);
   assign busy      = (state_q != SEQ_IDLE);

   // R7
   start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q == SEQ_SAMPLE && !samp_end)
      |=> (state_q == SEQ_SAMPLE && $stable(ch_q) && $stable(idx_q)));

   // R6
   slot_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (idx_q <= last_q));

   // R5
   first_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> (ch_sel == $past(slots_flat[CH_W-1:0])));

endmodule

// File: rtl/adc_seq_regs.sv
module adc_seq_regs
   import adc_seq_pkg::*;
#(
   parameter int unsigned NUM_CH = 19,
   parameter int unsigned CH_W   = 5,
   parameter int unsigned LEN_W  = 4,
   parameter int unsigned RES_W  = 12
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [ADDR_W-1:0]             addr,
   input  logic [BUS_W-1:0]              wdata,
   input  logic                          we,
   input  logic                          re,
   output logic [BUS_W-1:0]              rdata,
   input  logic [RES_W-1:0]              result,
   input  logic                          conv_done,
   output logic                          start,
   output logic                          scan,
   output logic [1:0]                    res_code,
   output logic [1:0]                    presc,
   output logic [LEN_W-1:0]              seq_len,
   output logic [(2**LEN_W)*CH_W-1:0]    slots_flat,
   output logic [NUM_CH*SMP_CODE_W-1:0]  smp_flat,
   output logic                          eoc
);
   localparam int unsigned SLOTS = 2 ** LEN_W;
   localparam int unsigned SPW   = BUS_W / CH_W;        // slots per word
   localparam int unsigned CPW   = BUS_W / SMP_CODE_W;  // sample codes per word, capped below
   localparam int unsigned CPW_U = (CPW > 10) ? 10 : CPW;

   if (SLOTS > 3 * SPW) begin : g_slot_fit_chk
      $error("sequence slots do not fit the three sequence words");
   end
   if ((SLOTS - 2 * SPW) * CH_W > LEN_LSB) begin : g_len_fit_chk
      $error("slots overlap the length field");
   end
   if (NUM_CH > 2 * CPW_U || NUM_CH > 2 ** CH_W) begin : g_ch_fit_chk
      $error("channel count exceeds sample-code storage or channel width");
   end

   logic [BUS_W-1:0] ctrl1_q, smp_hi_q, smp_lo_q, seq1_q, seq2_q, seq3_q, common_q;
   logic [RES_W-1:0] data_q;
   logic [RES_W-1:0] res_mask;
   logic             eoc_q;
   logic             data_rd;
   int               keep_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl1_q  <= '0;
         smp_hi_q <= '0;
         smp_lo_q <= '0;
         seq1_q   <= '0;
         seq2_q   <= '0;
         seq3_q   <= '0;
         common_q <= '0;
      end else if (we) begin
         case (addr)
            A_CTRL1:  ctrl1_q  <= wdata;
            A_SMP_HI: smp_hi_q <= wdata;
            A_SMP_LO: smp_lo_q <= wdata;
            A_SEQ1:   seq1_q   <= wdata;
            A_SEQ2:   seq2_q   <= wdata;
            A_SEQ3:   seq3_q   <= wdata;
            A_COMMON: common_q <= wdata;
            default:  ;
         endcase
      end
   end

   assign start    = we && (addr == A_CTRL2) && wdata[START_BIT];
   assign scan     = ctrl1_q[SCAN_BIT];
   assign res_code = ctrl1_q[RES_LSB +: 2];
   assign presc    = common_q[PRE_LSB +: 2];
   assign seq_len  = seq1_q[LEN_LSB +: LEN_W];

   for (genvar g = 0; g < SLOTS; g++) begin : g_slot_map
      if (g < SPW) begin : g_w3
         assign slots_flat[g*CH_W +: CH_W] = seq3_q[g*CH_W +: CH_W];
      end else if (g < 2 * SPW) begin : g_w2
         assign slots_flat[g*CH_W +: CH_W] = seq2_q[(g-SPW)*CH_W +: CH_W];
      end else begin : g_w1
         assign slots_flat[g*CH_W +: CH_W] = seq1_q[(g-2*SPW)*CH_W +: CH_W];
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_smp_map
      if (g < CPW_U) begin : g_lo
         assign smp_flat[g*SMP_CODE_W +: SMP_CODE_W] = smp_lo_q[g*SMP_CODE_W +: SMP_CODE_W];
      end else begin : g_hi
         assign smp_flat[g*SMP_CODE_W +: SMP_CODE_W] = smp_hi_q[(g-CPW_U)*SMP_CODE_W +: SMP_CODE_W];
      end
   end

   always_comb begin
      keep_w = int'(RES_W) - 2 * int'(res_code);
      for (int b = 0; b < RES_W; b++) res_mask[b] = (b < keep_w);
   end

   assign data_rd = re && (addr == A_DATA);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_q <= '0;
         eoc_q  <= 1'b0;
      end else if (conv_done) begin
         data_q <= result & res_mask;
         eoc_q  <= 1'b1;
      end else if (data_rd) begin
         eoc_q  <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      if (re) begin
         case (addr)
            A_STATUS: rdata = BUS_W'(eoc_q) << EOC_BIT;
            A_CTRL1:  rdata = ctrl1_q;
            A_SMP_HI: rdata = smp_hi_q;
            A_SMP_LO: rdata = smp_lo_q;
            A_SEQ1:   rdata = seq1_q;
            A_SEQ2:   rdata = seq2_q;
            A_SEQ3:   rdata = seq3_q;
            A_DATA:   rdata = BUS_W'(data_q);
            A_COMMON: rdata = common_q;
            default:  rdata = '0;
         endcase
      end
   end

   assign eoc = eoc_q;

   // R8
   eoc_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(eoc_q) |-> $past(conv_done));

   // R9
   eoc_read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !conv_done) |=> !eoc_q);

   // R9
   eoc_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |=> eoc_q);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
   import adc_seq_pkg::*;
#(
   parameter int unsigned NUM_CH = 19,
   parameter int unsigned CH_W   = 5,
   parameter int unsigned LEN_W  = 4,
   parameter int unsigned RES_W  = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        bus_addr,
   input  logic [31:0]       bus_wdata,
   input  logic              bus_we,
   input  logic              bus_re,
   output logic [31:0]       bus_rdata,
   input  logic [RES_W-1:0]  conv_result,
   output logic [CH_W-1:0]   ch_sel,
   output logic              sample_en,
   output logic              eoc
);
   localparam int unsigned SLOTS = 2 ** LEN_W;

   if (RES_W < 8) begin : g_res_chk
      $error("full resolution must leave room for the 6-bit mode");
   end

   logic                          start;
   logic                          scan;
   logic [1:0]                    res_code;
   logic [1:0]                    presc;
   logic [LEN_W-1:0]              seq_len;
   logic [SLOTS*CH_W-1:0]         slots_flat;
   logic [NUM_CH*SMP_CODE_W-1:0]  smp_flat;
   logic                          conv_done;
   logic                          div_restart;
   logic                          tick;
   logic                          busy;

   adc_seq_regs #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W),
      .LEN_W  (LEN_W),
      .RES_W  (RES_W)
   ) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .addr       (bus_addr),
      .wdata      (bus_wdata),
      .we         (bus_we),
      .re         (bus_re),
      .rdata      (bus_rdata),
      .result     (conv_result),
      .conv_done  (conv_done),
      .start      (start),
      .scan       (scan),
      .res_code   (res_code),
      .presc      (presc),
      .seq_len    (seq_len),
      .slots_flat (slots_flat),
      .smp_flat   (smp_flat),
      .eoc        (eoc)
   );

   adc_clk_div #(
      .PRE_W (2)
   ) u_div (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (div_restart),
      .presc   (presc),
      .tick    (tick)
   );

   adc_seq_fsm #(
      .NUM_CH (NUM_CH),
      .CH_W   (CH_W),
      .LEN_W  (LEN_W),
      .RES_W  (RES_W)
   ) u_fsm (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .tick        (tick),
      .scan        (scan),
      .seq_len     (seq_len),
      .res_code    (res_code),
      .slots_flat  (slots_flat),
      .smp_flat    (smp_flat),
      .ch_sel      (ch_sel),
      .sample_en   (sample_en),
      .busy        (busy),
      .conv_done   (conv_done),
      .div_restart (div_restart)
   );

   // R8
   done_only_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      conv_done |-> (busy && !sample_en));

endmodule

// File: tb/adc_seq_ctrl_tb.sv
`timescale 1ns/1ps
module adc_seq_ctrl_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_we = 1'b0;
   logic        bus_re = 1'b0;
   logic [31:0] bus_rdata;
   logic [11:0] conv_result = 12'h5a3;
   logic [4:0]  ch_sel;
   logic        sample_en;
   logic        eoc;

   always #2.5 clk = ~clk;

   adc_seq_ctrl u_dut (
      .clk         (clk),
      .rst_n       (rst_n),
      .bus_addr    (bus_addr),
      .bus_wdata   (bus_wdata),
      .bus_we      (bus_we),
      .bus_re      (bus_re),
      .bus_rdata   (bus_rdata),
      .conv_result (conv_result),
      .ch_sel      (ch_sel),
      .sample_en   (sample_en),
      .eoc         (eoc)
   );

   int checks = 0;
   int errors = 0;

   task automatic check(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // ---------------- reference model ----------------
   logic [31:0] w_ctrl1 = 0, w_smp_hi = 0, w_smp_lo = 0, w_seq1 = 0, w_seq2 = 0, w_seq3 = 0, w_common = 0;
   int  m_phase = 0, m_rem = 0, m_ch = 0, m_eoc = 0, m_data = 0;
   int  m_conv_now = 0, m_res_run = 0;
   int  q_ch[$], q_s[$], q_c[$];
   bit  m_done;
   bit  model_on = 0;

   function automatic int samp_tab(input int c);
      case (c)
         0: return 3;   1: return 15;  2: return 28;  3: return 56;
         4: return 84;  5: return 112; 6: return 144;
         default: return 480;
      endcase
   endfunction

   function automatic int slot_of(input int i);
      if (i < 6)  return int'((w_seq3 >> (5*i)) & 31);
      if (i < 12) return int'((w_seq2 >> (5*(i-6))) & 31);
      return int'((w_seq1 >> (5*(i-12))) & 31);
   endfunction

   function automatic int smp_of(input int ch);
      if (ch < 10) return int'((w_smp_lo >> (3*ch)) & 7);
      if (ch < 19) return int'((w_smp_hi >> (3*(ch-10))) & 7);
      return 0;
   endfunction

   task automatic model_pop();
      m_ch       = q_ch.pop_front();
      m_rem      = q_s.pop_front();
      m_conv_now = q_c.pop_front();
      m_phase    = 1;
   endtask

   task automatic model_start();
      int n, cnt, ch;
      n = 2 * (int'((w_common >> 16) & 3) + 1);
      m_res_run = int'((w_ctrl1 >> 24) & 3);
      cnt = w_ctrl1[8] ? int'((w_seq1 >> 20) & 15) + 1 : 1;
      for (int i = 0; i < cnt; i++) begin
         ch = slot_of(i);
         q_ch.push_back(ch);
         q_s.push_back(samp_tab(smp_of(ch)) * n);
         q_c.push_back((15 - 2 * m_res_run) * n);
      end
      model_pop();
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         m_phase = 0; m_rem = 0; m_ch = 0; m_eoc = 0; m_data = 0;
         w_ctrl1 = 0; w_smp_hi = 0; w_smp_lo = 0; w_seq1 = 0; w_seq2 = 0; w_seq3 = 0; w_common = 0;
      end else begin
         m_done = 0;
         if (m_phase == 1) begin
            m_rem--;
            if (m_rem == 0) begin m_phase = 2; m_rem = m_conv_now; end
         end else if (m_phase == 2) begin
            m_rem--;
            if (m_rem == 0) begin
               m_done = 1;
               m_data = int'(conv_result) & ((1 << (12 - 2 * m_res_run)) - 1);
               m_eoc  = 1;
               if (q_ch.size() > 0) model_pop();
               else m_phase = 0;
            end
         end else if (bus_we && bus_addr == 4'd2 && bus_wdata[30]) begin
            model_start();
         end
         if (bus_re && bus_addr == 4'd8 && !m_done) m_eoc = 0;
         if (bus_we) begin
            case (bus_addr)
               4'd1: w_ctrl1  = bus_wdata;
               4'd3: w_smp_hi = bus_wdata;
               4'd4: w_smp_lo = bus_wdata;
               4'd5: w_seq1   = bus_wdata;
               4'd6: w_seq2   = bus_wdata;
               4'd7: w_seq3   = bus_wdata;
               4'd9: w_common = bus_wdata;
               default: ;
            endcase
         end
      end
   end

   // ---------------- per-cycle comparison and measurement ----------------
   int cyc = 0, run_len = 0, last_win = 0, sen_rises = 0, sen_fall_cyc = 0, eoc_rise_cyc = 0;
   logic prev_sen = 0, prev_eoc = 0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n && model_on) begin
         check("R2", "sample_en vs model", int'(sample_en), int'(m_phase == 1));
         check("R5", "ch_sel vs model", int'(ch_sel), m_ch);
         check("R8", "eoc vs model", int'(eoc), m_eoc);
      end
      if (sample_en) begin
         run_len++;
         if (!prev_sen) sen_rises++;
      end else if (prev_sen) begin
         last_win = run_len; run_len = 0; sen_fall_cyc = cyc;
      end
      if (eoc && !prev_eoc) eoc_rise_cyc = cyc;
      prev_sen = sample_en;
      prev_eoc = eoc;
      conv_result <= 12'(conv_result * 5 + 12'h3a7);
   end

   // ---------------- bus tasks ----------------
   task automatic wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output int v);
      @(negedge clk);
      bus_re = 1'b1; bus_addr = a;
      #1 v = int'(bus_rdata);
      @(negedge clk);
      bus_re = 1'b0;
   endtask

   task automatic wait_idle();
      while (m_phase != 0) @(negedge clk);
      repeat (3) @(negedge clk);
   endtask

   task automatic cfg(input int pre, input int res, input int scn, input int len, input int seq1_slots);
      wr(4'd9, 32'(pre << 16));
      wr(4'd1, 32'((res << 24) | (scn << 8)));
      wr(4'd5, 32'((len << 20) | seq1_slots));
   endtask

   task automatic go_single(input int exp_win, input int exp_gap, input int width, input string tag);
      int v, r0;
      rd(4'd8, v);
      r0 = sen_rises;
      wr(4'd2, 32'h4000_0000);
      wait_idle();
      check("R2", {tag, " window length"}, last_win, exp_win);
      check("R3", {tag, " conversion gap"}, eoc_rise_cyc - sen_fall_cyc, exp_gap);
      check("R6", {tag, " one conversion"}, sen_rises - r0, 1);
      rd(4'd0, v);
      check("R8", {tag, " status word"}, v, 2);
      rd(4'd8, v);
      check("R4", {tag, " data"}, v, m_data);
      check("R4", {tag, " upper bits"}, v >> width, 0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   // ---------------- stimulus ----------------
   initial begin
      int v, r0, old;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      model_on = 1;
      @(negedge clk);
      // R10 reset state
      check("R10", "sample_en after reset", int'(sample_en), 0);
      check("R10", "eoc after reset", int'(eoc), 0);
      check("R10", "ch_sel after reset", int'(ch_sel), 0);
      rd(4'd8, v); check("R10", "data after reset", v, 0);
      rd(4'd0, v); check("R10", "status after reset", v, 0);

      // R7: bit 30 clear does nothing
      wr(4'd2, 32'h3fff_ffff);
      repeat (10) @(negedge clk);
      check("R7", "no start without bit 30", int'(sample_en), 0);

      // A: ratio 4, 12-bit, channel 4 code 000
      cfg(1, 0, 0, 0, 0);
      wr(4'd7, 32'd4);
      wr(4'd4, 32'd0);
      go_single(3 * 4, 15 * 4, 12, "R1 A");

      // C: ratio 6, 8-bit, scan off with length 3, channel 2 code 100, start while busy
      cfg(2, 2, 0, 3, 0);
      wr(4'd7, 32'd2 | (32'd9 << 5));
      wr(4'd4, 32'(4 << 6));
      rd(4'd8, v);
      r0 = sen_rises;
      wr(4'd2, 32'h4000_0000);
      repeat (20) @(negedge clk);
      wr(4'd2, 32'h4000_0000);   // R7 ignored while running
      wait_idle();
      check("R7", "window not restarted", last_win, 84 * 6);
      check("R6", "scan off gives one conversion", sen_rises - r0, 1);
      check("R3", "8-bit conversion gap", eoc_rise_cyc - sen_fall_cyc, 11 * 6);
      rd(4'd8, v);
      check("R4", "8-bit data", v, m_data);
      check("R4", "8-bit upper bits", v >> 8, 0);

      // D: ratio 8, 6-bit, channel 0 code 111
      cfg(3, 3, 0, 0, 0);
      wr(4'd7, 32'd0);
      wr(4'd4, 32'd7);
      go_single(480 * 8, 9 * 8, 6, "R1 D");

      // B: scan, length 2, slots 3/7/18 with codes 001/010/011, ratio 2, 10-bit
      cfg(0, 1, 1, 2, 0);
      wr(4'd7, 32'd3 | (32'd7 << 5) | (32'd18 << 10));
      wr(4'd4, 32'(1 << 9) | 32'(2 << 21));
      wr(4'd3, 32'(3 << 24));
      r0 = sen_rises;
      wr(4'd2, 32'h4000_0000);
      wait_idle();
      check("R6", "scan length 2 gives three conversions", sen_rises - r0, 3);
      check("R5", "last slot channel 18 window", last_win, 56 * 2);
      check("R5", "channel held after sequence", int'(ch_sel), 18);
      rd(4'd8, v);
      check("R4", "10-bit data", v, m_data);
      check("R4", "10-bit upper bits", v >> 10, 0);

      // E: scan, codes 101/110/100 on channels 5/6/9, ratio 2, 12-bit
      cfg(0, 0, 1, 2, 0);
      wr(4'd7, 32'd5 | (32'd6 << 5) | (32'd9 << 10));
      wr(4'd4, 32'(5 << 15) | 32'(6 << 18) | 32'(4 << 27));
      r0 = sen_rises;
      wr(4'd2, 32'h4000_0000);
      wait_idle();
      check("R2", "code 100 window on channel 9", last_win, 84 * 2);
      check("R6", "three conversions", sen_rises - r0, 3);

      // F: all sixteen slots, length 15
      cfg(0, 0, 1, 15, 1 | (1 << 5) | (1 << 10) | (1 << 15));
      wr(4'd7, 32'h0210_8421);
      wr(4'd6, 32'h0210_8421);
      wr(4'd4, 32'd0);
      r0 = sen_rises;
      wr(4'd2, 32'h4000_0000);
      wait_idle();
      check("R6", "length 15 gives sixteen conversions", sen_rises - r0, 16);

      // G: read and completion in the same cycle
      cfg(0, 0, 0, 0, 0);
      wr(4'd7, 32'd4);
      rd(4'd8, v);
      check("R9", "read clears flag", int'(eoc), 0);
      wr(4'd2, 32'h4000_0000);
      while (!(m_phase == 2 && m_rem == 1)) @(negedge clk);
      old = m_data;
      bus_re = 1'b1; bus_addr = 4'd8;
      #1 v = int'(bus_rdata);
      check("R9", "collision read returns previous data", v, old);
      @(negedge clk);
      bus_re = 1'b0;
      check("R9", "flag set wins over read", int'(eoc), 1);
      wait_idle();

      // R9: data register ignores writes
      rd(4'd8, old);
      wr(4'd8, 32'hffff_ffff);
      rd(4'd8, v);
      check("R9", "data unchanged by write", v, old);

      repeat (5) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule